// File: doc/BRIEF.md
# Video Controller Register Port

This block is the processor-side register front end of a character-based video timing controller. A processor first latches a 5-bit register index with a select strobe, then writes data to, or reads data from, the selected register. Sixteen writable configuration bytes (index 0 to 15) are stored here and presented as one flat bus to the timing logic. Two further read-only bytes (index 16 and 17) pass through a light pen address that is captured elsewhere.

A build-time parameter picks one of three read maps. The plain map returns stored values only for the start-address and cursor-address bytes. The plain map with status hides the start-address bytes, returns all ones at index 31, and keeps a pen-capture flag that the processor can poll. The aliased map decodes only the low three index bits, so every readable byte appears four times across the 32 indexes.

Writes are masked to the width each field has, and writes to read-only or absent indexes are dropped. Reads are combinational from the current index. A read strobe has no side effect except clearing the pen flag.

Top module: `vcr_regport`

## Requirements
- R1: After reset the index is 0, every stored byte on `reg_file` is 0 and `stat_rdata` is 0.
- R2: A data write to index n (0 to 15) stores `wdata` masked to the field width: low 7 bits for n = 4, 5, 6, 7, 10; low 5 bits for n = 9, 11; low 6 bits for n = 12, 14; all 8 bits otherwise. Byte n is `reg_file[8n+7:8n]`.
- R3: A data write while the index is 16 to 31 changes no stored byte, and a later read of 16 or 17 still returns the pen address.
- R4: With VARIANT=0, `rdata` is the stored byte for index 12 to 15, `{2'b00, pen_addr[13:8]}` for 16, `pen_addr[7:0]` for 17, and 0 for every other index.
- R5: With VARIANT=1, reads match R4 except that indexes 12 and 13 return 0 and index 31 returns 8'hFF.
- R6: With VARIANT=2, `rdata` depends only on index bits 2..0: 0 gives the pen high byte, 1 the pen low byte, 2 to 7 give stored bytes 10 to 15 in that order.
- R7: With VARIANT=1, a `pen_capture` pulse sets status bit 6 (`stat_rdata` = 8'h40) from the next cycle; all other status bits, and the whole status byte in the other variants, read 0.
- R8: With VARIANT=1, a `rd_en` pulse while the index is 16 or 17 clears status bit 6 from the next cycle; a read of any other index leaves it set, and a capture in the same cycle as the clearing read wins.
- R9: `sel_wr` loads the index from `wdata[4:0]`; when `sel_wr` and `data_wr` arrive together the data goes to the old index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_wr | input | 1 | Load register index from wdata |
| data_wr | input | 1 | Write wdata to the selected register |
| rd_en | input | 1 | Read strobe for the selected register |
| wdata | input | 8 | Write data and index value |
| pen_capture | input | 1 | One-cycle pulse when a new pen address is captured |
| pen_addr | input | 14 | Captured light pen address |
| rdata | output | 8 | Read data of the selected register |
| stat_rdata | output | 8 | Status byte |
| reg_file | output | 128 | Stored bytes 0 to 15, byte n at bits 8n+7:8n |

## Verification
The hardest case is the clear-versus-set race on the pen flag: a capture pulse must land in exactly the cycle a read strobe hits index 16, which the bench arranges by driving both strobes at the same falling edge after having parked the index there. The read maps are swept over all 32 indexes on three instances, one per variant, that share every input, so each alias and every absent index is compared against a shadow of the bytes the table wrote.

// File: rtl/vcr_regport_pkg.sv
// Package: shared constants and field-width rules for the video
// controller register port. Assumes 8-bit data and 5-bit indexes.
package vcr_regport_pkg;
    localparam int REG_W   = 8;
    localparam int IDX_W   = 5;
    localparam int PEN_HI  = 16;   // index of pen address high byte
    localparam int PEN_LO  = 17;   // index of pen address low byte
    localparam int DUMMY_IX = 31;  // index that reads all ones in status map
    localparam int STAT_BIT = 6;   // status bit set by a pen capture

    // read-map variants
    localparam int MAP_PLAIN  = 0;
    localparam int MAP_STATUS = 1;
    localparam int MAP_ALIAS  = 2;

    // Field width mask applied to a write at a given index.
    function automatic logic [REG_W-1:0] field_mask(input int idx);
        case (idx)
            4, 5, 6, 7, 10: field_mask = 8'h7F;
            9, 11:          field_mask = 8'h1F;
            12, 14:         field_mask = 8'h3F;
            default:        field_mask = 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/vcr_regport_bank.sv
// Index latch and writable register storage.
// Assumes: writes at or above NSTORE are dropped; a simultaneous index
// load and data write uses the index held before the edge.
module vcr_regport_bank
    import vcr_regport_pkg::*;
#(
    parameter int NSTORE = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_wr,
    input  logic                      data_wr,
    input  logic [REG_W-1:0]          wdata,
    output logic [IDX_W-1:0]          cur_idx,
    output logic [NSTORE*REG_W-1:0]   reg_file
);
    logic [REG_W-1:0] mem [NSTORE];

    // Index latch: loads the selected register number.
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_idx <= '0;
        else if (sel_wr) cur_idx <= wdata[IDX_W-1:0];
    end

    // Storage bytes: one write port per byte, masked to field width.
    for (genvar g = 0; g < NSTORE; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (data_wr && (int'(cur_idx) == g))
                mem[g] <= wdata & field_mask(g);
        end
        assign reg_file[g*REG_W +: REG_W] = mem[g];
    end
endmodule

// File: rtl/vcr_regport_rdmux.sv
// Read decode: selects the read byte for the current index.
// Assumes: NSTORE >= 16 so stored bytes 10..15 exist; PEN_W in 9..16.
module vcr_regport_rdmux
    import vcr_regport_pkg::*;
#(
    parameter int VARIANT = MAP_PLAIN,
    parameter int NSTORE  = 16,
    parameter int PEN_W   = 14
) (
    input  logic [IDX_W-1:0]        cur_idx,
    input  logic [NSTORE*REG_W-1:0] reg_file,
    input  logic [PEN_W-1:0]        pen_addr,
    output logic [REG_W-1:0]        rdata
);
    localparam int HI_W = PEN_W - REG_W;

    logic [REG_W-1:0] pen_hi, pen_lo;
    assign pen_hi = {{(2*REG_W-PEN_W){1'b0}}, pen_addr[PEN_W-1 -: HI_W]};
    assign pen_lo = pen_addr[REG_W-1:0];

    function automatic logic [REG_W-1:0] byte_at(
        input logic [NSTORE*REG_W-1:0] rf, input int n);
        byte_at = rf[n*REG_W +: REG_W];
    endfunction

    // Read selection for the chosen map.
    always_comb begin
        rdata = '0;
        if (VARIANT == MAP_ALIAS) begin
            case (cur_idx[2:0])
                3'd0:    rdata = pen_hi;
                3'd1:    rdata = pen_lo;
                default: rdata = byte_at(reg_file, 8 + int'(cur_idx[2:0]));
            endcase
        end else begin
            case (int'(cur_idx))
                12, 13:  rdata = (VARIANT == MAP_PLAIN) ?
                                 byte_at(reg_file, int'(cur_idx)) : '0;
                14, 15:  rdata = byte_at(reg_file, int'(cur_idx));
                PEN_HI:  rdata = pen_hi;
                PEN_LO:  rdata = pen_lo;
                DUMMY_IX: rdata = (VARIANT == MAP_STATUS) ? '1 : '0;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/vcr_regport_status.sv
// Pen-capture status flag, present only in the status map.
// Assumes: capture has priority over the clearing read.
module vcr_regport_status
    import vcr_regport_pkg::*;
#(
    parameter int VARIANT = MAP_PLAIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             pen_capture,
    input  logic [IDX_W-1:0] cur_idx,
    output logic [REG_W-1:0] stat_rdata
);
    localparam bit HAS_FLAG = (VARIANT == MAP_STATUS);

    logic flag;
    logic pen_read;
    assign pen_read = rd_en &&
        ((int'(cur_idx) == PEN_HI) || (int'(cur_idx) == PEN_LO));

    // Flag register: set on capture, cleared on a pen address read.
    always_ff @(posedge clk) begin
        if (!rst_n || !HAS_FLAG) flag <= 1'b0;
        else if (pen_capture)    flag <= 1'b1;
        else if (pen_read)       flag <= 1'b0;
    end

    // Status byte: only the flag bit can be non-zero.
    always_comb begin
        stat_rdata = '0;
        stat_rdata[STAT_BIT] = flag;
    end
endmodule

// File: rtl/vcr_regport.sv
// Top: processor-side register port of a video timing controller.
// Assumes: synchronous active-low reset; reads are combinational from
// the latched index; VARIANT picks the read map (0 plain, 1 status, 2 aliased).
module vcr_regport
    import vcr_regport_pkg::*;
#(
    parameter int VARIANT = MAP_PLAIN,
    parameter int NSTORE  = 16,
    parameter int PEN_W   = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_wr,
    input  logic                      data_wr,
    input  logic                      rd_en,
    input  logic [REG_W-1:0]          wdata,
    input  logic                      pen_capture,
    input  logic [PEN_W-1:0]          pen_addr,
    output logic [REG_W-1:0]          rdata,
    output logic [REG_W-1:0]          stat_rdata,
    output logic [NSTORE*REG_W-1:0]   reg_file
);
    logic [IDX_W-1:0] cur_idx;

    vcr_regport_bank #(.NSTORE(NSTORE)) u_bank (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .data_wr(data_wr),
        .wdata(wdata), .cur_idx(cur_idx), .reg_file(reg_file)
    );

    vcr_regport_rdmux #(.VARIANT(VARIANT), .NSTORE(NSTORE), .PEN_W(PEN_W)) u_rdmux (
        .cur_idx(cur_idx), .reg_file(reg_file), .pen_addr(pen_addr),
        .rdata(rdata)
    );

    vcr_regport_status #(.VARIANT(VARIANT)) u_status (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .pen_capture(pen_capture),
        .cur_idx(cur_idx), .stat_rdata(stat_rdata)
    );
endmodule

// File: rtl/vcr_regport_chk.sv
// Checker: temporal properties of the register port, bound to the top.
module vcr_regport_chk
    import vcr_regport_pkg::*;
#(
    parameter int VARIANT = MAP_PLAIN,
    parameter int NSTORE  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sel_wr,
    input logic                    data_wr,
    input logic                    rd_en,
    input logic [REG_W-1:0]        wdata,
    input logic                    pen_capture,
    input logic [REG_W-1:0]        rdata,
    input logic [REG_W-1:0]        stat_rdata,
    input logic [NSTORE*REG_W-1:0] reg_file,
    input logic [IDX_W-1:0]        cur_idx
);
    logic pen_ix;
    assign pen_ix = (int'(cur_idx) == PEN_HI) || (int'(cur_idx) == PEN_LO);

    // R9: index latch follows the select strobe
    a_r9_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> cur_idx == $past(wdata[IDX_W-1:0]));

    // R3: writes at read-only or absent indexes leave storage unchanged
    a_r3_high_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && int'(cur_idx) >= NSTORE) |=> $stable(reg_file));

    // R7: a capture sets the flag in the status map
    a_r7_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (VARIANT == MAP_STATUS && pen_capture) |=> stat_rdata[STAT_BIT]);

    // R7: no other status bit is ever set, nor any bit outside the status map
    a_r7_other_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(stat_rdata) == ((VARIANT == MAP_STATUS) ? int'(stat_rdata[STAT_BIT]) : 0));

    // R8: a pen address read without a capture clears the flag
    a_r8_pen_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && pen_ix && !pen_capture) |=> stat_rdata == '0);

    // R8: a read elsewhere keeps the flag
    a_r8_other_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdata[STAT_BIT] && !(rd_en && pen_ix)) |=> stat_rdata[STAT_BIT]);

    // R4: plain map returns zero below the start-address bytes
    a_r4_low_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (VARIANT != MAP_ALIAS && int'(cur_idx) < 12) |-> rdata == '0);
endmodule

bind vcr_regport vcr_regport_chk #(.VARIANT(VARIANT), .NSTORE(NSTORE)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .data_wr(data_wr),
    .rd_en(rd_en), .wdata(wdata), .pen_capture(pen_capture),
    .rdata(rdata), .stat_rdata(stat_rdata), .reg_file(reg_file),
    .cur_idx(cur_idx)
);

// File: tb/tb_vcr_regport.sv
`timescale 1ns/1ps
// Bench: three instances (plain, status, aliased maps) on shared inputs.
module tb_vcr_regport;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel_wr = 1'b0, data_wr = 1'b0, rd_en = 1'b0, pen_capture = 1'b0;
    logic [7:0]   wdata = '0;
    logic [13:0]  pen_addr = 14'h2ABC;
    logic [7:0]   rd0, rd1, rd2, st0, st1, st2;
    logic [127:0] rf0, rf1, rf2;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] sh [16];

    always #4 clk = ~clk;

    vcr_regport #(.VARIANT(0)) dut (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .data_wr(data_wr), .rd_en(rd_en),
        .wdata(wdata), .pen_capture(pen_capture), .pen_addr(pen_addr),
        .rdata(rd0), .stat_rdata(st0), .reg_file(rf0));
    vcr_regport #(.VARIANT(1)) dut1 (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .data_wr(data_wr), .rd_en(rd_en),
        .wdata(wdata), .pen_capture(pen_capture), .pen_addr(pen_addr),
        .rdata(rd1), .stat_rdata(st1), .reg_file(rf1));
    vcr_regport #(.VARIANT(2)) dut2 (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .data_wr(data_wr), .rd_en(rd_en),
        .wdata(wdata), .pen_capture(pen_capture), .pen_addr(pen_addr),
        .rdata(rd2), .stat_rdata(st2), .reg_file(rf2));

    // write vectors: {index, written value, expected stored value} (R2)
    localparam logic [20:0] WVEC [10] = '{
        {5'd4,  8'hFF, 8'h7F}, {5'd9,  8'hFF, 8'h1F}, {5'd12, 8'hFF, 8'h3F},
        {5'd13, 8'hA5, 8'hA5}, {5'd14, 8'hC3, 8'h03}, {5'd15, 8'h5A, 8'h5A},
        {5'd10, 8'hFF, 8'h7F}, {5'd11, 8'hFF, 8'h1F}, {5'd0,  8'h3F, 8'h3F},
        {5'd6,  8'h81, 8'h01}};

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic select(input int i);
        @(negedge clk); sel_wr = 1'b1; wdata = 8'(i);
        @(negedge clk); sel_wr = 1'b0;
    endtask

    task automatic write(input logic [7:0] v);
        @(negedge clk); data_wr = 1'b1; wdata = v;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic rd_pulse(input bit cap);
        @(negedge clk); rd_en = 1'b1; pen_capture = cap;
        @(negedge clk); rd_en = 1'b0; pen_capture = 1'b0;
    endtask

    task automatic capture;
        @(negedge clk); pen_capture = 1'b1;
        @(negedge clk); pen_capture = 1'b0;
    endtask

    function automatic logic [7:0] exp_rd(input int v, input int i);
        logic [7:0] hi, lo;
        hi = {2'b00, pen_addr[13:8]};
        lo = pen_addr[7:0];
        if (v == 2) begin
            case (i % 8)
                0: return hi;
                1: return lo;
                default: return sh[8 + i % 8];
            endcase
        end
        case (i)
            12, 13: return (v == 0) ? sh[i] : 8'h00;
            14, 15: return sh[i];
            16: return hi;
            17: return lo;
            31: return (v == 1) ? 8'hFF : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [127:0] shadow_flat();
        logic [127:0] f;
        for (int k = 0; k < 16; k++) f[k*8 +: 8] = sh[k];
        return f;
    endfunction

    initial begin
        for (int k = 0; k < 16; k++) sh[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 reg_file", rf0, '0);
        check("R1 status", st1, 8'h00);
        check("R1 index0 read", rd0, 8'h00);

        // table walk: masked writes (R2)
        for (int e = 0; e < 10; e++) begin
            select(int'(WVEC[e][20:16]));
            write(WVEC[e][15:8]);
            sh[WVEC[e][20:16]] = WVEC[e][7:0];
            @(negedge clk);
            check($sformatf("R2 idx%0d", WVEC[e][20:16]), rf0, shadow_flat());
        end
        check("R2 dut1 same storage", rf1, shadow_flat());
        check("R2 dut2 same storage", rf2, shadow_flat());

        // R3: writes at 16, 17, 20, 31 are dropped
        foreach (WVEC[e]) begin end
        select(16); write(8'h77);
        select(17); write(8'h66);
        select(20); write(8'h55);
        select(31); write(8'h44);
        @(negedge clk);
        check("R3 storage unchanged", rf0, shadow_flat());
        select(16);
        check("R3 pen hi still read", rd0, 8'h2A);

        // R4 R5 R6: sweep all indexes
        for (int i = 0; i < 32; i++) begin
            select(i);
            check($sformatf("R4 idx%0d", i), rd0, exp_rd(0, i));
            check($sformatf("R5 idx%0d", i), rd1, exp_rd(1, i));
            check($sformatf("R6 idx%0d", i), rd2, exp_rd(2, i));
        end

        // R9: combined select and write goes to old index
        select(13);
        @(negedge clk); sel_wr = 1'b1; data_wr = 1'b1; wdata = 8'h0E;
        @(negedge clk); sel_wr = 1'b0; data_wr = 1'b0;
        sh[13] = 8'h0E;
        check("R9 old index written", rf0, shadow_flat());
        check("R9 new index read", rd0, sh[14]);

        // R7: capture sets status bit 6 only in status map
        capture();
        check("R7 status set", st1, 8'h40);
        check("R7 plain no status", st0, 8'h00);
        check("R7 alias no status", st2, 8'h00);
        // R8: read of index 15 keeps flag
        select(15); rd_pulse(1'b0);
        check("R8 other read keeps", st1, 8'h40);
        // R8: read of 16 clears
        select(16); rd_pulse(1'b0);
        check("R8 hi read clears", st1, 8'h00);
        capture();
        select(17); rd_pulse(1'b0);
        check("R8 lo read clears", st1, 8'h00);
        // R8: capture in the same cycle as a clearing read wins
        select(16); rd_pulse(1'b1);
        check("R8 capture wins", st1, 8'h40);
        // pen address change seen at read (R4)
        pen_addr = 14'h1F03;
        @(negedge clk);
        check("R4 pen hi new", rd0, 8'h1F);
        check("R6 alias idx16 pen hi", rd2, 8'h1F);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule